// File: doc/BRIEF.md
# UART Baud Tick Generator

This block makes the oversampling tick for a serial port's transmit and receive shifters. A down-counter is loaded with a 16-bit reload value. It counts at either the full input clock or half of it, and gives a one-cycle tick each time it wraps. The shifters sample 16 ticks per bit, so the fastest bit rate is the input clock divided by 16. With the halving stage chosen, the reload for a bit rate `baud` is `clk / (16 * baud) / 2 - 1`.

Software drives the block through one narrow write port that selects one of two registers:

- **Control word:** holds the run bit, the prescale selection and a fractional-divider enable bit. That enable bit is stored but has no effect here.
- **Reload value.**

Reprogramming is safe in this order: clear the run bit, write the control fields and the reload, then set the run bit again. A rising run bit restarts the prescaler and the counter from a known state.

Top module: `baud_tick_gen`

## Requirements
- R1: After synchronous reset, the run bit, the prescale bypass, the fractional enable and the reload value are all 0, and `tick_o` is low. Starting the generator with only the run bit set therefore gives a tick period of 2 clocks.
- R2: A write with `wr_sel`=0 updates the control word. Bit 15 is run, bit 8 is prescale bypass (1 = no halving stage) and bit 9 is the fractional enable. A write with `wr_sel`=1 updates the reload value from `wr_data[15:0]`.
- R3: With bit 8 = 0 and reload R, the tick period is 2*(R+1) clocks.
- R4: With bit 8 = 1 and reload R, the tick period is R+1 clocks (R=0 holds `tick_o` high every cycle).
- R5: Whenever the period exceeds one clock, `tick_o` is high for exactly one clock per period.
- R6: A control write that takes the run bit from 0 to 1 restarts the prescaler and the counter. The first tick is then seen exactly one period after the clock edge that accepts the write.
- R7: While the run bit is 0, `tick_o` stays low.
- R8: A reload write while running does not disturb the count in progress. The interval then in progress keeps the old length, and later periods use the new value.
- R9: A control write with the run bit set while the generator is already running does not restart the count.
- R10: The fractional enable bit (bit 9) has no effect on tick timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = reload value |
| wr_data | input | 16 | Write data |
| tick_o | output | 1 | Registered oversampling tick |

## Verification
Two functions can fall in the same cycle:

- **Reload write at a wrap.** A reload write can land just after the counter has wrapped and reloaded. The bench waits for a tick and issues the write on the very next edge. The interval then in progress must keep its old length of 10 clocks, and only the interval after it may shrink to 5.
- **Control write with run already set.** A control write can arrive while the counter is mid-count. The bench rewrites the control word one edge after a tick and requires the next tick exactly one old period later, where a spurious restart would add one clock.

Each table entry also restarts the generator from a running state with a different prescale choice. This checks that the prescaler phase is cleared along with the counter.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  localparam int RUN_BIT  = 15;
  localparam int FRAC_BIT = 9;
  localparam int PSEL_BIT = 8;

  typedef struct packed {
    logic run;
    logic frac_en;
    logic bypass;
  } bg_cfg_t;
endpackage

// File: rtl/baudgen_regs.sv
module baudgen_regs
  import baudgen_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RELOAD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  output bg_cfg_t             cfg_o,
  output logic [RELOAD_W-1:0] reload_o,
  output logic                start_o
);
  logic cfg_wr;
  logic rld_wr;

  assign cfg_wr  = wr_en && !wr_sel;
  assign rld_wr  = wr_en && wr_sel;
  // run bit rising: restart prescaler and counter at this same edge
  assign start_o = cfg_wr && wr_data[RUN_BIT] && !cfg_o.run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o    <= '0;
      reload_o <= '0;
    end else begin
      if (cfg_wr) begin
        cfg_o.run     <= wr_data[RUN_BIT];
        cfg_o.frac_en <= wr_data[FRAC_BIT];
        cfg_o.bypass  <= wr_data[PSEL_BIT];
      end
      if (rld_wr)
        reload_o <= wr_data[RELOAD_W-1:0];
    end
  end
endmodule

// File: rtl/baudgen_prescale.sv
module baudgen_prescale (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic run_i,
  input  logic bypass_i,
  output logic ce_o
);
  logic half_q;

  assign ce_o = run_i && (bypass_i || half_q);

  always_ff @(posedge clk) begin
    if (rst || start_i)
      half_q <= 1'b0;
    else if (run_i)
      half_q <= !half_q;
  end
endmodule

// File: rtl/baudgen_counter.sv
module baudgen_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_i,
  input  logic         run_i,
  input  logic         ce_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o  <= '0;
      tick_o <= 1'b0;
    end else if (start_i) begin
      cnt_o  <= reload_i;
      tick_o <= 1'b0;
    end else if (!run_i) begin
      tick_o <= 1'b0;
    end else if (ce_i) begin
      if (cnt_o == '0) begin
        cnt_o  <= reload_i;
        tick_o <= 1'b1;
      end else begin
        cnt_o  <= cnt_o - 1'b1;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baudgen_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RELOAD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              tick_o
);
  bg_cfg_t             cfg_q;
  logic [RELOAD_W-1:0] reload_q;
  logic [RELOAD_W-1:0] cnt_q;
  logic                start_w;
  logic                ce_w;
  logic                run_w;
  logic                bypass_w;

  assign run_w    = cfg_q.run;
  assign bypass_w = cfg_q.bypass;

  baudgen_regs #(.DATA_W(DATA_W), .RELOAD_W(RELOAD_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg_o(cfg_q), .reload_o(reload_q), .start_o(start_w)
  );

  baudgen_prescale pre_i (
    .clk(clk), .rst(rst), .start_i(start_w), .run_i(run_w),
    .bypass_i(bypass_w), .ce_o(ce_w)
  );

  baudgen_counter #(.W(RELOAD_W)) cnt_i (
    .clk(clk), .rst(rst), .start_i(start_w), .run_i(run_w), .ce_i(ce_w),
    .reload_i(reload_q), .cnt_o(cnt_q), .tick_o(tick_o)
  );
endmodule

// File: rtl/baudgen_chk.sv
module baudgen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         run,
  input logic         bypass,
  input logic         start,
  input logic         ce,
  input logic         wr_en,
  input logic         tick,
  input logic [W-1:0] cnt,
  input logic [W-1:0] reload
);
  p_stopped_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> !tick);

  p_restart_load_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> (!tick && cnt == $past(reload)));

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run && ce && !start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1 && !tick));

  p_wrap_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (run && ce && !start && cnt == '0) |=> (tick && cnt == $past(reload)));

  p_narrow_tick_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !bypass && tick && !wr_en) |=> !tick);
endmodule

bind baud_tick_gen baudgen_chk #(.W(RELOAD_W)) chk_i (
  .clk(clk), .rst(rst), .run(run_w), .bypass(bypass_w), .start(start_w),
  .ce(ce_w), .wr_en(wr_en), .tick(tick_o), .cnt(cnt_q), .reload(reload_q)
);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        tick_o;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  localparam int LIM = 5000;
  // columns: bypass (bit 8), frac (bit 9), reload, expected period
  localparam int NV = 7;
  localparam int VEC [NV][4] = '{
    '{1, 0, 0, 1},
    '{1, 0, 5, 6},
    '{0, 0, 0, 2},
    '{0, 0, 3, 8},
    '{0, 1, 3, 8},
    '{0, 0, 9, 20},
    '{1, 1, 15, 16}
  };

  always #2 clk = !clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .tick_o(tick_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // entered and left at a falling edge; the write is taken at the rising edge between
  task automatic wr(input logic sel, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts falling edges from the current one until tick_o is seen high
  task automatic wait_tick(input int k0, output int k);
    k = k0;
    while (!tick_o && k < LIM) begin
      @(negedge clk);
      k++;
    end
  endtask

  function automatic logic [15:0] cfg(input int run, input int byp, input int frac);
    logic [15:0] v;
    v = '0;
    v[15] = (run != 0);
    v[8]  = (byp != 0);
    v[9]  = (frac != 0);
    return v;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    int highs;
    bit second_low;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: quiet after reset
    highs = 0;
    for (int i = 0; i < 50; i++) begin
      if (tick_o) highs++;
      @(negedge clk);
    end
    chk("R1 reset ticks", highs, 0);

    // R1/R2: reset reload 0 and halving stage -> period 2
    wr(1'b0, cfg(1, 0, 0));
    wait_tick(0, k);
    chk("R1 R6 first latency from reset values", k, 2);
    @(negedge clk);
    wait_tick(1, k);
    chk("R1 period from reset values", k, 2);

    // table walk: R2 R3 R4 R5 R6 R10
    for (int v = 0; v < NV; v++) begin
      wr(1'b0, cfg(0, VEC[v][0], VEC[v][1]));
      wr(1'b1, 16'(VEC[v][2]));
      wr(1'b0, cfg(1, VEC[v][0], VEC[v][1]));
      wait_tick(0, k);
      chk($sformatf("R6 R2 first latency vec %0d", v), k, VEC[v][3]);
      @(negedge clk);
      second_low = !tick_o;
      wait_tick(1, k);
      if (VEC[v][0] != 0)
        chk($sformatf("R4 R10 period vec %0d", v), k, VEC[v][3]);
      else
        chk($sformatf("R3 R10 period vec %0d", v), k, VEC[v][3]);
      if (VEC[v][3] > 1)
        chk($sformatf("R5 one-cycle tick vec %0d", v), int'(second_low), 1);
    end

    // R7: stopping silences the tick
    wr(1'b0, cfg(0, 1, 0));
    wr(1'b1, 16'd2);
    wr(1'b0, cfg(1, 1, 0));
    repeat (7) @(negedge clk);
    wr(1'b0, cfg(0, 1, 0));
    highs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tick_o) highs++;
    end
    chk("R7 ticks while stopped", highs, 0);

    // R9 and R8: writes that land right after a wrap
    wr(1'b1, 16'd9);
    wr(1'b0, cfg(1, 1, 0));
    wait_tick(0, k);
    wr(1'b0, cfg(1, 1, 0));
    wait_tick(1, k);
    chk("R9 no restart on run rewrite", k, 10);
    wr(1'b1, 16'd4);
    wait_tick(1, k);
    chk("R8 interval in progress keeps old reload", k, 10);
    @(negedge clk);
    wait_tick(1, k);
    chk("R8 next period uses new reload", k, 5);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule